// File: doc/BRIEF.md
# Mode-Selectable Serial Shift Register

This block is an 8-bit serial shifter inside a memory-mapped peripheral. Software reaches its data register at one address of a 4-bit register space. A 3-bit mode input, taken from a neighbouring control register, picks one of eight behaviours. The shifter can be off. It can shift in from a serial data pin, or shift out onto a serial data pin. The shift clock comes from one of three sources: pulses from a companion timer, every cycle of the system clock, or rising edges on an external clock pin.

Any access to the data register starts a fresh 8-bit sequence and clears the completion flag. In the counted modes the flag rises after exactly eight shift clocks, and any further clocks are ignored until the next access. One output mode runs free: on every timer pulse it rotates the byte, so the same byte repeats on the data pin and the flag never rises. For the internal clock sources the block drives the clock pin. In the external modes it releases the pin and samples it.

Top module: `sr_shift_unit`

## Requirements
- R1: After reset the data register is 0x00, `doneFlag` is 0, `cbOut` is 1 and, with `modeSel` = 000, `cbOe` is 0.
- R2: A write with `addr` = 0xA loads `wrData` into the data register at the clock edge. A read with `addr` = 0xA returns the current content on `rdData` in the same cycle. Accesses to any other address leave the register unchanged, and `rdData` reads 0 there.
- R3: With `modeSel` = 000 no shift ever happens, `doneFlag` stays 0 and `cbOe` is 0.
- R4: In the shift-in modes (001, 010, 011) each shift clock moves the register one place toward the MSB and takes `serIn` into bit 0.
- R5: `serOut` always shows bit 7. In the shift-out modes (100, 101, 110, 111) each shift clock rotates the register left: bit 7 goes to bit 0.
- R6: In modes 001 and 101, one shift happens on every clock edge where `timerTick` is 1 and a sequence is running. Cycles with `timerTick` at 0 do not shift.
- R7: In modes 010 and 110, one shift happens on every clock edge while a sequence is running.
- R8: In modes 011 and 111, `cbOe` is 0. A shift happens on an edge where `cbIn` is sampled 1 after it was sampled 0 at the previous edge. Holding `cbIn` high gives only one shift.
- R9: In modes 001, 010, 011, 101, 110 and 111, `doneFlag` rises on the edge of the eighth shift. Further shift clocks are then ignored until the next access.
- R10: A read or write at 0xA clears `doneFlag` and restarts the 8-shift count. If an access falls on the same edge as a shift, the access wins and no shift happens.
- R11: In mode 100, every `timerTick` edge rotates the register whether or not a sequence is running, and `doneFlag` is never set.
- R12: In the internal-clock modes (001, 010, 100, 101, 110), `cbOe` is 1. `cbOut` toggles on each shift and returns to 1 on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address of the bus access |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data; 0 unless the shifter is read |
| modeSel | input | 3 | Shifter mode from the control register |
| timerTick | input | 1 | One-cycle underflow pulse from the companion timer |
| serIn | input | 1 | Serial data input |
| serOut | output | 1 | Serial data output (register MSB) |
| cbIn | input | 1 | Sampled level of the shift-clock pin |
| cbOut | output | 1 | Level driven onto the shift-clock pin |
| cbOe | output | 1 | Output enable for the shift-clock pin |
| doneFlag | output | 1 | Set when eight bits have been shifted |

## Verification
The risky overlap is a bus access to 0xA that lands on the same edge as the eighth shift clock. At that edge the count would set the flag while the access clears it and reloads the data. The bench provokes this in the system-clock output mode: it writes a new byte exactly seven edges after a restart. It then requires the flag to stay low, the new byte's MSB to appear on the data pin, and a full further eight shifts before the flag rises and the new byte reads back intact.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'b000,
    MODE_IN_TMR   = 3'b001,
    MODE_IN_SYS   = 3'b010,
    MODE_IN_EXT   = 3'b011,
    MODE_OUT_FREE = 3'b100,
    MODE_OUT_TMR  = 3'b101,
    MODE_OUT_SYS  = 3'b110,
    MODE_OUT_EXT  = 3'b111
  } srMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // take parallel write data
    logic restart;    // any access: reset clock pin level
    logic shift;      // perform one shift this edge
    logic dirIn;      // 1: take serIn, 0: rotate
    logic clkToggle;  // toggle internally driven clock pin
  } srStrobe_t;

endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       access,
  input  logic       write,
  input  logic       timerTick,
  input  logic       cbIn,
  output srStrobe_t  strobe,
  output logic       doneFlag,
  output logic       cbOe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  srMode_t mode;
  logic isOff, isFree, isExt, srcTmr, srcSys;
  logic cbPrev, cbRise, rawClk, shiftEn;
  logic active;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    mode   = srMode_t'(modeSel);
    isOff  = (mode == MODE_OFF);
    isFree = (mode == MODE_OUT_FREE);
    isExt  = (modeSel[1:0] == 2'b11);
    srcTmr = (modeSel[1:0] == 2'b01) || isFree;
    srcSys = (modeSel[1:0] == 2'b10);
    cbRise = cbIn && !cbPrev;
    if (srcTmr)      rawClk = timerTick;
    else if (srcSys) rawClk = 1'b1;
    else if (isExt)  rawClk = cbRise;
    else             rawClk = 1'b0;
    shiftEn = !access && rawClk && (isFree || (active && !isOff));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbPrev   <= 1'b0;
      active   <= 1'b0;
      bitCnt   <= '0;
      doneFlag <= 1'b0;
    end else begin
      cbPrev <= cbIn;
      if (access) begin
        active   <= 1'b1;
        bitCnt   <= '0;
        doneFlag <= 1'b0;
      end else if (shiftEn && !isFree) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST) begin
          active   <= 1'b0;
          doneFlag <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load      = access && write;
    strobe.restart   = access;
    strobe.shift     = shiftEn;
    strobe.dirIn     = !modeSel[2];
    strobe.clkToggle = shiftEn && !isExt;
    cbOe             = !isOff && !isExt;
  end

endmodule

// File: rtl/sr_path.sv
module sr_path
  import sr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  srStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              serIn,
  output logic [DATA_W-1:0] dataQ,
  output logic              serOut,
  output logic              cbOut
);

  logic newLsb;

  always_comb begin
    newLsb = strobe.dirIn ? serIn : dataQ[DATA_W-1];
    serOut = dataQ[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      cbOut <= 1'b1;
    end else begin
      if (strobe.load)       dataQ <= wrData;
      else if (strobe.shift) dataQ <= {dataQ[DATA_W-2:0], newLsb};
      if (strobe.restart)        cbOut <= 1'b1;
      else if (strobe.clkToggle) cbOut <= !cbOut;
    end
  end

endmodule

// File: rtl/sr_shift_unit.sv
module sr_shift_unit
  import sr_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter int              ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] SR_ADDR = 4'hA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [2:0]        modeSel,
  input  logic              timerTick,
  input  logic              serIn,
  output logic              serOut,
  input  logic              cbIn,
  output logic              cbOut,
  output logic              cbOe,
  output logic              doneFlag
);

  logic sel, access, write;
  logic [DATA_W-1:0] dataQ;
  srStrobe_t strobe;

  always_comb begin
    sel    = (addr == SR_ADDR);
    access = sel && (wrEn || rdEn);
    write  = sel && wrEn;
    rdData = (sel && rdEn) ? dataQ : '0;
  end

  sr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .access(access), .write(write),
    .timerTick(timerTick), .cbIn(cbIn), .strobe(strobe), .doneFlag(doneFlag), .cbOe(cbOe)
  );

  sr_path #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .serIn(serIn),
    .dataQ(dataQ), .serOut(serOut), .cbOut(cbOut)
  );

endmodule

// File: rtl/sr_shift_unit_chk.sv
module sr_shift_unit_chk #(
  parameter int                DATA_W  = 8,
  parameter int                ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] SR_ADDR = 4'hA
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic              wrMsb,
  input logic [2:0]        modeSel,
  input logic              serOut,
  input logic              doneFlag
);

  logic acc;
  assign acc = (addr == SR_ADDR) && (wrEn || rdEn);

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == SR_ADDR) |=> (serOut == $past(wrMsb)));

  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'b000 && $past(modeSel) == 3'b000 && !$past(acc)) |-> $stable(serOut));

  // R10
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> !doneFlag);

  // R9
  rise_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !$past(acc));

  // R11
  free_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(modeSel) != 3'b100 && $past(modeSel) != 3'b000));

endmodule

bind sr_shift_unit sr_shift_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SR_ADDR(SR_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrMsb(wrData[DATA_W-1]), .modeSel(modeSel), .serOut(serOut), .doneFlag(doneFlag)
);

// File: tb/sr_shift_unit_tb.sv
module sr_shift_unit_tb;

  localparam logic [3:0] SRA = 4'hA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [2:0] modeSel = 3'b000;
  logic timerTick = 1'b0, serIn = 1'b0, cbIn = 1'b0;
  logic serOut, cbOut, cbOe, doneFlag;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  sr_shift_unit u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .modeSel(modeSel), .timerTick(timerTick), .serIn(serIn),
    .serOut(serOut), .cbIn(cbIn), .cbOut(cbOut), .cbOe(cbOe), .doneFlag(doneFlag)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rotl(logic [7:0] v, int n);
    for (int i = 0; i < n; i++) v = {v[6:0], v[7]};
    return v;
  endfunction

  // monitor: pops expected read values
  always @(negedge clk) begin
    if (rstN && rdEn && addr == SRA) begin
      if (expQ.size() == 0) chk("R2 unexpected read", rdData, 8'hxx);
      else chk(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [7:0] v);
    addr = SRA; wrEn = 1'b1; wrData = v;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] exp, string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    addr = SRA; rdEn = 1'b1;
    step();
    rdEn = 1'b0;
  endtask

  task automatic tick();
    step();
    timerTick = 1'b1;
    step();
    timerTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] pat;
    repeat (3) step();
    @(negedge clk);
    chk("R1 flag", {7'd0, doneFlag}, 8'h0);
    chk("R1 serOut", {7'd0, serOut}, 8'h0);
    chk("R1 cbOut", {7'd0, cbOut}, 8'h1);
    chk("R1 cbOe", {7'd0, cbOe}, 8'h0);
    step(); rstN = 1'b1; step();

    // R3 disabled mode, R2 decode
    modeSel = 3'b000;
    wr(8'hA5);
    repeat (4) tick();
    @(negedge clk);
    chk("R3 flag", {7'd0, doneFlag}, 8'h0);
    chk("R3 cbOe", {7'd0, cbOe}, 8'h0);
    chk("R3 serOut", {7'd0, serOut}, 8'h1);
    step();
    rd(8'hA5, "R3 data kept");
    addr = 4'h9; wrEn = 1'b1; wrData = 8'hFF; step(); wrEn = 1'b0;
    addr = 4'h9; rdEn = 1'b1;
    @(negedge clk);
    chk("R2 other addr rdData", rdData, 8'h00);
    step(); rdEn = 1'b0;
    rd(8'hA5, "R2 other addr ignored");

    // R4 R7 R9 shift in on system clock
    modeSel = 3'b010;
    pat = 8'h6B;
    wr(8'h00);
    for (int i = 7; i >= 0; i--) begin
      serIn = pat[i];
      @(negedge clk);
      chk("R9 flag early", {7'd0, doneFlag}, 8'h0);
      step();
    end
    @(negedge clk);
    chk("R9 flag at eighth", {7'd0, doneFlag}, 8'h1);
    serIn = 1'b1;
    step(); step(); step();
    rd(pat, "R4 R7 shifted in");
    @(negedge clk);
    chk("R10 read clears flag", {7'd0, doneFlag}, 8'h0);
    step();

    // R5 R12 shift out on system clock
    modeSel = 3'b110;
    wr(8'hB4);
    @(negedge clk);
    chk("R12 cbOe", {7'd0, cbOe}, 8'h1);
    chk("R12 cbOut restart", {7'd0, cbOut}, 8'h1);
    chk("R5 first bit", {7'd0, serOut}, 8'h1);
    for (int k = 1; k <= 8; k++) begin
      step();
      @(negedge clk);
      chk("R5 serOut", {7'd0, serOut}, {7'd0, rotl(8'hB4, k) >> 7});
      chk("R12 cbOut toggle", {7'd0, cbOut}, {7'd0, (k % 2 == 0)});
    end
    chk("R9 out flag", {7'd0, doneFlag}, 8'h1);
    step(); step();
    chk("R9 stopped", {7'd0, serOut}, 8'h1);
    rd(8'hB4, "R5 rotated back");
    // R10 collision: write on the eighth shift edge
    repeat (7) step();
    wr(8'h5C);
    @(negedge clk);
    chk("R10 collision flag", {7'd0, doneFlag}, 8'h0);
    chk("R10 collision serOut", {7'd0, serOut}, 8'h0);
    step();
    repeat (7) step();
    @(negedge clk);
    chk("R10 restarted count", {7'd0, doneFlag}, 8'h1);
    step();
    rd(8'h5C, "R10 new byte kept");

    // R6 shift in on timer
    modeSel = 3'b001;
    pat = 8'hC9;
    wr(8'h00);
    for (int i = 7; i >= 0; i--) begin
      serIn = ~pat[i];
      step();
      serIn = pat[i];
      timerTick = 1'b1;
      step();
      timerTick = 1'b0;
    end
    @(negedge clk);
    chk("R6 flag", {7'd0, doneFlag}, 8'h1);
    step();
    rd(pat, "R6 timer shift in");

    // R6 shift out on timer
    modeSel = 3'b101;
    wr(8'hE1);
    for (int k = 1; k <= 8; k++) begin
      tick();
      @(negedge clk);
      chk("R6 out serOut", {7'd0, serOut}, {7'd0, rotl(8'hE1, k) >> 7});
    end
    step();
    rd(8'hE1, "R6 timer shift out");

    // R11 free-running
    modeSel = 3'b100;
    wr(8'h81);
    repeat (10) tick();
    @(negedge clk);
    chk("R11 no flag", {7'd0, doneFlag}, 8'h0);
    chk("R12 free cbOe", {7'd0, cbOe}, 8'h1);
    step();
    rd(rotl(8'h81, 10), "R11 recirculated");

    // R8 external clock in
    modeSel = 3'b011;
    pat = 8'h5A;
    wr(8'h00);
    @(negedge clk);
    chk("R8 cbOe", {7'd0, cbOe}, 8'h0);
    step();
    for (int i = 7; i >= 0; i--) begin
      serIn = pat[i];
      cbIn = 1'b1;
      step(); step();
      cbIn = 1'b0;
      step();
    end
    @(negedge clk);
    chk("R8 flag", {7'd0, doneFlag}, 8'h1);
    step();
    serIn = 1'b1; cbIn = 1'b1; step(); cbIn = 1'b0; step();
    rd(pat, "R8 R9 ext shift in");

    // R8 external clock out
    modeSel = 3'b111;
    wr(8'h96);
    for (int k = 1; k <= 8; k++) begin
      cbIn = 1'b1; step(); cbIn = 1'b0; step();
      @(negedge clk);
      chk("R8 out serOut", {7'd0, serOut}, {7'd0, rotl(8'h96, k) >> 7});
    end
    step();
    rd(8'h96, "R8 ext shift out");
    step();
    chk("R2 all reads seen", 8'(expQ.size()), 8'h0);
    finishRun();
  end

endmodule